// File: doc/BRIEF.md
# Audio Stream Lifecycle Controller

This block governs one direction of an audio stream (transmit or receive, picked by a parameter) through five states: not-ready, ready, running, stopping and error. Software-side requests arrive as single-cycle command strobes carrying an opcode (configure, start, stop, drain, drop, prepare) and as single-cycle block requests (write a block for transmit, read a block for receive). The serial data path reports each finished block and any underrun or overrun. From these the block keeps a small count of queued blocks, drives a run enable for the serializer and a one-cycle queue flush strobe, and answers every request one cycle later with a response code.

Stop and drain differ: stop ends the stream after the block in flight, keeping the rest of the queue so a later start resumes from there, while drain on a transmit stream keeps playing until the queue is empty. Every command is legal only in certain states, and an illegal one is refused with an I/O error and leaves the state alone.

Top module: `stream_lifecycle_ctrl`

## Requirements
- R1: Configure (opcode 0) is accepted only in not-ready or ready and moves to ready, or to not-ready when the zero-rate flag is set with it; in any other state it is refused with code 1 and the state holds. States encode not-ready 0, ready 1, running 2, stopping 3, error 4.
- R2: Start (opcode 1) is accepted only in ready and moves to running; on a transmit stream with an empty queue it is refused with code 3 (no data) and the state holds; a receive stream starts with an empty queue.
- R3: Stop (opcode 2) is accepted only in running and moves to stopping; the next block-done then moves to ready, the queue keeps its remaining blocks and a later start resumes with them.
- R4: Drain (opcode 3) is accepted only in running; on transmit it stays in stopping while blocks remain and reaches ready on the block-done that empties the queue, or goes straight to ready when the queue is already empty; on receive it behaves as stop.
- R5: Drop (opcode 4) is accepted in every state except not-ready; it moves to ready at once, clears the queue count and raises the flush output for exactly one cycle, aligned with the response; in not-ready it is refused with code 1.
- R6: An underrun/overrun event while running or stopping forces error and lowers run enable; a command in the same cycle is refused with code 1. Prepare (opcode 5) is accepted only in error, moves to ready and clears the queue.
- R7: A block write (write flag 1) is accepted with code 0 only on a transmit stream in ready or running and adds one block; with the queue full it answers code 2 (busy) and the count holds; otherwise it answers code 1.
- R8: A block read (write flag 0) is accepted only on a receive stream outside not-ready: with blocks queued it answers code 0 and removes one; with an empty queue it answers code 1 in error or not-ready and code 2 otherwise; on a transmit stream it answers code 1.
- R9: A command refused with code 1, including opcodes 6 and 7, leaves the state unchanged.
- R10: Each command and each block request gets exactly one response, valid for one cycle, on the cycle after its strobe; codes are 0 accepted, 1 I/O error, 2 busy, 3 no data.
- R11: After reset the state is not-ready, the queue count is 0 and run enable is low; run enable is high exactly in running and stopping, and block-done outside those states leaves the count unchanged.
- R12: The queue count never exceeds QUEUE_DEPTH (at least 2); on transmit block-done removes a block, on receive block-done adds one and saturates at full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 3 | Command opcode |
| cmdRateZero | input | 1 | With configure: frame rate is zero |
| blkValid | input | 1 | Block request strobe, one cycle |
| blkWrite | input | 1 | 1 = block write, 0 = block read |
| blockDone | input | 1 | Data path finished one block |
| xrunEvent | input | 1 | Data path underrun or overrun |
| streamState | output | 3 | Current lifecycle state |
| runEn | output | 1 | Serializer run enable |
| flushQueue | output | 1 | One-cycle queue discard strobe |
| queueLevel | output | $clog2(QUEUE_DEPTH+1) | Queued block count |
| cmdRspValid | output | 1 | Command response valid |
| cmdRspCode | output | 2 | Command response code |
| blkRspValid | output | 1 | Block response valid |
| blkRspCode | output | 2 | Block response code |

## Verification
The bench builds two instances side by side: a transmit stream with QUEUE_DEPTH 2 and a receive stream with QUEUE_DEPTH 3. The two-deep transmit queue reaches full after two writes, so the busy answer, the stop-then-resume path and a two-step drain all fit in a few commands. The three-deep receive instance brings the receive-only variant within reach: block-done saturating at full, drain acting as stop, and reads that keep succeeding in error until the queue empties.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [2:0] {
    ST_NOT_READY = 3'd0,
    ST_READY     = 3'd1,
    ST_RUNNING   = 3'd2,
    ST_STOPPING  = 3'd3,
    ST_ERROR     = 3'd4
  } streamStateE;

  localparam logic [2:0] OP_CONFIG  = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_DRAIN   = 3'd3;
  localparam logic [2:0] OP_DROP    = 3'd4;
  localparam logic [2:0] OP_PREPARE = 3'd5;

  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_EIO   = 2'd1;
  localparam logic [1:0] RSP_BUSY  = 2'd2;
  localparam logic [1:0] RSP_NOMEM = 2'd3;

  // Strobes from control to the queue datapath
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       clear;
    logic       cmdAck;
    logic [1:0] cmdCode;
    logic       blkAck;
    logic [1:0] blkCode;
  } qCtrlT;

endpackage

// File: rtl/slc_control.sv
module slc_control
  import slc_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              cmdRateZero,
  input  logic              blkValid,
  input  logic              blkWrite,
  input  logic              blockDone,
  input  logic              xrunEvent,
  input  logic [CNT_W-1:0]  qCount,
  input  logic              qEmpty,
  input  logic              qFull,
  output streamStateE       state,
  output qCtrlT             ctl
);

  localparam logic [CNT_W-1:0] ONE_BLK = CNT_W'(1);

  streamStateE nextState;
  logic drainMode, nextDrain;
  logic active, xrunHit;
  logic donePush, donePop;

  assign active  = (state == ST_RUNNING) || (state == ST_STOPPING);
  assign xrunHit = xrunEvent && active;

  // Direction picks which side of the queue a finished block touches
  generate
    if (IS_TX) begin : g_tx
      assign donePush = 1'b0;
      assign donePop  = blockDone && active && !qEmpty;
    end else begin : g_rx
      assign donePush = blockDone && active && !qFull;
      assign donePop  = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextDrain = drainMode;

    ctl.push = donePush;
    ctl.pop  = donePop;

    // Completion of a stop or drain
    if (state == ST_STOPPING) begin
      if (!drainMode || !IS_TX) begin
        if (blockDone) nextState = ST_READY;
      end else if (qEmpty || (donePop && qCount == ONE_BLK)) begin
        nextState = ST_READY;
      end
    end

    // Block requests
    if (blkValid) begin
      ctl.blkAck = 1'b1;
      if (blkWrite) begin
        if (!IS_TX || !((state == ST_READY) || (state == ST_RUNNING))) begin
          ctl.blkCode = RSP_EIO;
        end else if (qFull) begin
          ctl.blkCode = RSP_BUSY;
        end else begin
          ctl.blkCode = RSP_OK;
          ctl.push    = 1'b1;
        end
      end else begin
        if (IS_TX || state == ST_NOT_READY) begin
          ctl.blkCode = RSP_EIO;
        end else if (!qEmpty) begin
          ctl.blkCode = RSP_OK;
          ctl.pop     = 1'b1;
        end else if (state == ST_ERROR) begin
          ctl.blkCode = RSP_EIO;
        end else begin
          ctl.blkCode = RSP_BUSY;
        end
      end
    end

    // Commands
    if (cmdValid) begin
      ctl.cmdAck  = 1'b1;
      ctl.cmdCode = RSP_EIO;
      if (!xrunHit) begin
        case (cmdOp)
          OP_CONFIG: begin
            if (state == ST_NOT_READY || state == ST_READY) begin
              ctl.cmdCode = RSP_OK;
              nextState   = cmdRateZero ? ST_NOT_READY : ST_READY;
            end
          end
          OP_START: begin
            if (state == ST_READY) begin
              if (IS_TX && qEmpty) begin
                ctl.cmdCode = RSP_NOMEM;
              end else begin
                ctl.cmdCode = RSP_OK;
                nextState   = ST_RUNNING;
                nextDrain   = 1'b0;
              end
            end
          end
          OP_STOP: begin
            if (state == ST_RUNNING) begin
              ctl.cmdCode = RSP_OK;
              nextState   = ST_STOPPING;
              nextDrain   = 1'b0;
            end
          end
          OP_DRAIN: begin
            if (state == ST_RUNNING) begin
              ctl.cmdCode = RSP_OK;
              if (IS_TX && qEmpty) begin
                nextState = ST_READY;
              end else begin
                nextState = ST_STOPPING;
                nextDrain = IS_TX;
              end
            end
          end
          OP_DROP: begin
            if (state != ST_NOT_READY) begin
              ctl.cmdCode = RSP_OK;
              nextState   = ST_READY;
              ctl.clear   = 1'b1;
            end
          end
          OP_PREPARE: begin
            if (state == ST_ERROR) begin
              ctl.cmdCode = RSP_OK;
              nextState   = ST_READY;
              ctl.clear   = 1'b1;
            end
          end
          default: ctl.cmdCode = RSP_EIO;
        endcase
      end
    end

    if (xrunHit) nextState = ST_ERROR;

    if (ctl.clear) begin
      ctl.push = 1'b0;
      ctl.pop  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_NOT_READY;
      drainMode <= 1'b0;
    end else begin
      state     <= nextState;
      drainMode <= nextDrain;
    end
  end

endmodule

// File: rtl/slc_queue.sv
module slc_queue
  import slc_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  qCtrlT            ctl,
  output logic [CNT_W-1:0] qCount,
  output logic             qEmpty,
  output logic             qFull,
  output logic             flushOut,
  output logic             cmdRspValid,
  output logic [1:0]       cmdRspCode,
  output logic             blkRspValid,
  output logic [1:0]       blkRspCode
);

  localparam logic [CNT_W-1:0] DEPTH_L = CNT_W'(QUEUE_DEPTH);

  assign qEmpty = (qCount == '0);
  assign qFull  = (qCount == DEPTH_L);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount      <= '0;
      flushOut    <= 1'b0;
      cmdRspValid <= 1'b0;
      cmdRspCode  <= RSP_OK;
      blkRspValid <= 1'b0;
      blkRspCode  <= RSP_OK;
    end else begin
      if (ctl.clear) begin
        qCount <= '0;
      end else begin
        case ({ctl.push, ctl.pop})
          2'b10:   qCount <= qCount + 1'b1;
          2'b01:   qCount <= qCount - 1'b1;
          default: qCount <= qCount;
        endcase
      end
      flushOut    <= ctl.clear;
      cmdRspValid <= ctl.cmdAck;
      cmdRspCode  <= ctl.cmdCode;
      blkRspValid <= ctl.blkAck;
      blkRspCode  <= ctl.blkCode;
    end
  end

endmodule

// File: rtl/stream_lifecycle_ctrl.sv
module stream_lifecycle_ctrl
  import slc_pkg::*;
#(
  parameter bit IS_TX       = 1'b1,
  parameter int QUEUE_DEPTH = 4,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdRateZero,
  input  logic             blkValid,
  input  logic             blkWrite,
  input  logic             blockDone,
  input  logic             xrunEvent,
  output logic [2:0]       streamState,
  output logic             runEn,
  output logic             flushQueue,
  output logic [CNT_W-1:0] queueLevel,
  output logic             cmdRspValid,
  output logic [1:0]       cmdRspCode,
  output logic             blkRspValid,
  output logic [1:0]       blkRspCode
);

  streamStateE curState;
  qCtrlT       qCtl;
  logic        qEmpty, qFull;

  slc_control #(.IS_TX(IS_TX), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRateZero(cmdRateZero),
    .blkValid(blkValid), .blkWrite(blkWrite),
    .blockDone(blockDone), .xrunEvent(xrunEvent),
    .qCount(queueLevel), .qEmpty(qEmpty), .qFull(qFull),
    .state(curState), .ctl(qCtl)
  );

  slc_queue #(.QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)) uQueue (
    .clk(clk), .rstN(rstN), .ctl(qCtl),
    .qCount(queueLevel), .qEmpty(qEmpty), .qFull(qFull),
    .flushOut(flushQueue),
    .cmdRspValid(cmdRspValid), .cmdRspCode(cmdRspCode),
    .blkRspValid(blkRspValid), .blkRspCode(blkRspCode)
  );

  assign streamState = curState;
  assign runEn       = (curState == ST_RUNNING) || (curState == ST_STOPPING);

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int QUEUE_DEPTH = 4,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic             cmdRateZero,
  input logic             blkValid,
  input logic             blkWrite,
  input logic             blockDone,
  input logic             xrunEvent,
  input logic [2:0]       streamState,
  input logic             runEn,
  input logic             flushQueue,
  input logic [CNT_W-1:0] queueLevel,
  input logic             cmdRspValid,
  input logic [1:0]       cmdRspCode,
  input logic             blkRspValid,
  input logic [1:0]       blkRspCode
);

  localparam logic [CNT_W-1:0] DEPTH_L = CNT_W'(QUEUE_DEPTH);

  a_r1_config_to_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd0 && !cmdRateZero && (streamState == 3'd0 || streamState == 3'd1))
    |=> (streamState == 3'd1 && cmdRspValid && cmdRspCode == 2'd0));

  a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd4 && streamState != 3'd0 && !(xrunEvent && runEn))
    |=> (streamState == 3'd1 && queueLevel == '0 && flushQueue));

  a_r6_xrun_to_error: assert property (@(posedge clk) disable iff (!rstN)
    (xrunEvent && runEn) |=> (streamState == 3'd4 && !runEn));

  a_r7_full_write_refused: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkWrite && queueLevel == DEPTH_L) |=> (blkRspValid && blkRspCode != 2'd0));

  a_r9_reject_holds_state: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !xrunEvent && !blockDone) |=> (cmdRspCode != 2'd1 || $stable(streamState)));

  a_r10_cmd_rsp_next: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> cmdRspValid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !blkValid) |=> (!cmdRspValid && !blkRspValid));

  a_r11_idle_done_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (blockDone && !runEn && !blkValid && !cmdValid) |=> $stable(queueLevel));

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    queueLevel <= DEPTH_L);

endmodule

bind stream_lifecycle_ctrl slc_checker #(.QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)) uChk (.*);

// File: tb/stream_lifecycle_ctrl_test.sv
module stream_lifecycle_ctrl_test;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] CFG = 3'd0, START = 3'd1, STOP = 3'd2, DRAIN = 3'd3,
                         DROP = 3'd4, PREP = 3'd5;
  localparam logic [1:0] OK = 2'd0, EIO = 2'd1, BUSY = 2'd2, NOMEM = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRateZero = 1'b0, blkValid = 1'b0, blkWrite = 1'b0;
  logic blockDone = 1'b0, xrunEvent = 1'b0, useRx = 1'b0;
  logic [2:0] cmdOp = 3'd0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [2:0] stT, stR;
  logic runT, runR, flT, flR, crvT, crvR, brvT, brvR;
  logic [1:0] lvlT;
  logic [1:0] lvlR;
  logic [1:0] crcT, crcR, brcT, brcR;

  stream_lifecycle_ctrl #(.IS_TX(1'b1), .QUEUE_DEPTH(2)) uut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid & ~useRx), .cmdOp(cmdOp), .cmdRateZero(cmdRateZero),
    .blkValid(blkValid & ~useRx), .blkWrite(blkWrite),
    .blockDone(blockDone & ~useRx), .xrunEvent(xrunEvent & ~useRx),
    .streamState(stT), .runEn(runT), .flushQueue(flT), .queueLevel(lvlT),
    .cmdRspValid(crvT), .cmdRspCode(crcT), .blkRspValid(brvT), .blkRspCode(brcT)
  );

  stream_lifecycle_ctrl #(.IS_TX(1'b0), .QUEUE_DEPTH(3)) uutRx (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid & useRx), .cmdOp(cmdOp), .cmdRateZero(cmdRateZero),
    .blkValid(blkValid & useRx), .blkWrite(blkWrite),
    .blockDone(blockDone & useRx), .xrunEvent(xrunEvent & useRx),
    .streamState(stR), .runEn(runR), .flushQueue(flR), .queueLevel(lvlR),
    .cmdRspValid(crvR), .cmdRspCode(crcR), .blkRspValid(brvR), .blkRspCode(brcR)
  );

  wire [2:0] curSt  = useRx ? stR : stT;
  wire       curRun = useRx ? runR : runT;
  wire       curFl  = useRx ? flR : flT;
  wire [1:0] curLvl = useRx ? lvlR : lvlT;
  wire       curCrv = useRx ? crvR : crvT;
  wire [1:0] curCrc = useRx ? crcR : crcT;
  wire       curBrv = useRx ? brvR : brvT;
  wire [1:0] curBrc = useRx ? brcR : brcT;

  typedef struct {
    bit         isBlk;
    logic [1:0] code;
    string      tag;
  } expT;

  expT sb[$];
  int nChecks = 0;
  int nFails = 0;
  int flushCnt = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (rstN) begin
      if (curFl) flushCnt++;
      if (curCrv) begin
        if (sb.size() == 0 || sb[0].isBlk) begin
          check(1'b0, "R10 unexpected command response", int'(curCrc), -1);
        end else begin
          check(curCrc == sb[0].code, sb[0].tag, int'(curCrc), int'(sb[0].code));
          void'(sb.pop_front());
        end
      end
      if (curBrv) begin
        if (sb.size() == 0 || !sb[0].isBlk) begin
          check(1'b0, "R10 unexpected block response", int'(curBrc), -1);
        end else begin
          check(curBrc == sb[0].code, sb[0].tag, int'(curBrc), int'(sb[0].code));
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic finishItem(string tag);
    #1;
    check(sb.size() == 0, {tag, " R10 response missing"}, sb.size(), 0);
    sb.delete();
  endtask

  task automatic issueCmd(logic [2:0] op, bit rz, bit xr, logic [1:0] code, string tag);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdRateZero = rz; xrunEvent = xr;
    sb.push_back('{1'b0, code, tag});
    @(negedge clk);
    cmdValid = 1'b0; cmdRateZero = 1'b0; xrunEvent = 1'b0;
    finishItem(tag);
  endtask

  task automatic issueBlk(bit wr, logic [1:0] code, string tag);
    @(negedge clk);
    blkValid = 1'b1; blkWrite = wr;
    sb.push_back('{1'b1, code, tag});
    @(negedge clk);
    blkValid = 1'b0;
    finishItem(tag);
  endtask

  task automatic pulse(bit isXrun);
    @(negedge clk);
    if (isXrun) xrunEvent = 1'b1; else blockDone = 1'b1;
    @(negedge clk);
    xrunEvent = 1'b0; blockDone = 1'b0;
    #1;
  endtask

  task automatic expectState(logic [2:0] st, int lvl, bit run, string tag);
    check(curSt == st, {tag, " state"}, int'(curSt), int'(st));
    check(int'(curLvl) == lvl, {tag, " level"}, int'(curLvl), lvl);
    check(curRun == run, {tag, " runEn"}, int'(curRun), int'(run));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // ---------------- transmit stream, depth 2 ----------------
    expectState(3'd0, 0, 1'b0, "R11 reset");
    issueBlk(1'b1, EIO, "R7 write in not-ready");
    issueCmd(START, 1'b0, 1'b0, EIO, "R9 start in not-ready");
    expectState(3'd0, 0, 1'b0, "R9 not-ready kept");
    issueCmd(CFG, 1'b0, 1'b0, OK, "R1 configure");
    expectState(3'd1, 0, 1'b0, "R1 ready");
    issueCmd(START, 1'b0, 1'b0, NOMEM, "R2 start empty transmit");
    expectState(3'd1, 0, 1'b0, "R2 ready kept");
    issueBlk(1'b1, OK, "R7 write 1");
    issueBlk(1'b1, OK, "R7 write 2");
    issueBlk(1'b1, BUSY, "R7 write full busy");
    expectState(3'd1, 2, 1'b0, "R12 full level");
    issueBlk(1'b0, EIO, "R8 read on transmit");
    pulse(1'b0);
    expectState(3'd1, 2, 1'b0, "R11 done ignored in ready");
    issueCmd(STOP, 1'b0, 1'b0, EIO, "R9 stop in ready");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 start");
    expectState(3'd2, 2, 1'b1, "R2 running");
    issueCmd(CFG, 1'b0, 1'b0, EIO, "R1 configure while running");
    expectState(3'd2, 2, 1'b1, "R1 running kept");
    issueCmd(STOP, 1'b0, 1'b0, OK, "R3 stop");
    expectState(3'd3, 2, 1'b1, "R3 stopping");
    pulse(1'b0);
    expectState(3'd1, 1, 1'b0, "R3 stop completes");
    issueCmd(START, 1'b0, 1'b0, OK, "R3 resume");
    expectState(3'd2, 1, 1'b1, "R3 resumed with queue");
    issueBlk(1'b1, OK, "R7 write running");
    issueCmd(DRAIN, 1'b0, 1'b0, OK, "R4 drain");
    expectState(3'd3, 2, 1'b1, "R4 stopping");
    pulse(1'b0);
    expectState(3'd3, 1, 1'b1, "R4 drain continues");
    pulse(1'b0);
    expectState(3'd1, 0, 1'b0, "R4 drain complete");
    issueBlk(1'b1, OK, "R7 write");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 start");
    issueCmd(STOP, 1'b0, 1'b1, EIO, "R6 command with underrun");
    expectState(3'd4, 1, 1'b0, "R6 error");
    issueBlk(1'b1, EIO, "R7 write in error");
    issueCmd(START, 1'b0, 1'b0, EIO, "R9 start in error");
    expectState(3'd4, 1, 1'b0, "R9 error kept");
    issueCmd(PREP, 1'b0, 1'b0, OK, "R6 prepare");
    expectState(3'd1, 0, 1'b0, "R6 prepare clears");
    issueCmd(PREP, 1'b0, 1'b0, EIO, "R6 prepare in ready");
    issueBlk(1'b1, OK, "R7 write");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 start");
    f0 = flushCnt;
    issueCmd(DROP, 1'b0, 1'b0, OK, "R5 drop running");
    expectState(3'd1, 0, 1'b0, "R5 drop");
    check(flushCnt == f0 + 1, "R5 flush pulse", flushCnt - f0, 1);
    issueCmd(DRAIN, 1'b0, 1'b0, EIO, "R9 drain in ready");
    issueBlk(1'b1, OK, "R7 write");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 start");
    pulse(1'b0);
    expectState(3'd2, 0, 1'b1, "R12 transmit done removes block");
    issueCmd(DRAIN, 1'b0, 1'b0, OK, "R4 drain empty");
    expectState(3'd1, 0, 1'b0, "R4 drain empty ready");
    issueCmd(3'd7, 1'b0, 1'b0, EIO, "R9 unknown opcode");
    expectState(3'd1, 0, 1'b0, "R9 unknown kept");
    issueCmd(CFG, 1'b1, 1'b0, OK, "R1 zero rate");
    expectState(3'd0, 0, 1'b0, "R1 back to not-ready");
    f0 = flushCnt;
    issueCmd(DROP, 1'b0, 1'b0, EIO, "R5 drop in not-ready");
    check(flushCnt == f0, "R5 no flush in not-ready", flushCnt - f0, 0);

    // ---------------- receive stream, depth 3 ----------------
    useRx = 1'b1;
    #1;
    expectState(3'd0, 0, 1'b0, "R11 receive reset");
    issueBlk(1'b0, EIO, "R8 read in not-ready");
    issueCmd(CFG, 1'b0, 1'b0, OK, "R1 receive configure");
    issueBlk(1'b0, BUSY, "R8 empty read busy");
    issueBlk(1'b1, EIO, "R7 write on receive");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 receive start empty");
    expectState(3'd2, 0, 1'b1, "R2 receive running");
    for (int i = 0; i < 4; i++) pulse(1'b0);
    expectState(3'd2, 3, 1'b1, "R12 receive saturates");
    issueBlk(1'b0, OK, "R8 read");
    expectState(3'd2, 2, 1'b1, "R8 read removes");
    issueCmd(DRAIN, 1'b0, 1'b0, OK, "R4 receive drain");
    expectState(3'd3, 2, 1'b1, "R4 receive stopping");
    pulse(1'b0);
    expectState(3'd1, 3, 1'b0, "R4 receive drain as stop");
    issueCmd(START, 1'b0, 1'b0, OK, "R2 receive restart");
    pulse(1'b1);
    expectState(3'd4, 3, 1'b0, "R6 overrun error");
    for (int i = 0; i < 3; i++) issueBlk(1'b0, OK, "R8 read in error");
    issueBlk(1'b0, EIO, "R8 read error empty");
    pulse(1'b0);
    expectState(3'd4, 0, 1'b0, "R11 done ignored in error");
    issueCmd(PREP, 1'b0, 1'b0, OK, "R6 receive prepare");
    expectState(3'd1, 0, 1'b0, "R6 receive ready");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule